// File: doc/BRIEF.md
# Field Identifier Detector from Separate Sync References

This block works out which field of an interlaced frame is arriving. It takes a horizontal and a vertical reference that come from outside the pixel-clock domain, brings both into that domain, and looks for one chosen edge of the vertical reference. At that edge it samples the level of the horizontal reference, and that level becomes the field identifier. A low level marks the first field of a frame and a high level marks the second field.

Two static control bits set the detection. One bit picks the rising or the falling vertical edge. The other bit inverts the result. A path-select bit can bypass the external detection and take a field identifier that an internal decoder supplies with a start strobe. The inversion bit also applies on that path.

The block outputs a registered field identifier. It also outputs two one-cycle pulses, one for a detected first-field start and one for a detected second-field start, which a task scheduler downstream uses as triggers.

Top module: `fid_detect`

## Requirements
- R1: While `rstN` is low, `fidOut`, `firstFieldPulse` and `secondFieldPulse` are all 0.
- R2: With `edgeSelRise`=0 and `invertFid`=0, a high-to-low change of `vRefIn` loads `fidOut` with the level of `hRefIn` at that change. A low-to-high change of `vRefIn` leaves `fidOut` unchanged.
- R3: With `edgeSelRise`=1, only a low-to-high change of `vRefIn` is a detection event. A high-to-low change leaves `fidOut` unchanged.
- R4: With `invertFid`=1, the loaded value is the complement of the sampled level. This holds on both the external path and the decoder path.
- R5: At each detection event, exactly one pulse is high for one cycle, in the same cycle that `fidOut` takes its new value. The pulse is `firstFieldPulse` when the new `fidOut` is 0 and `secondFieldPulse` when it is 1.
- R6: `fidOut` holds its value between detection events. A change of `hRefIn` with no qualifying `vRefIn` edge has no effect on it.
- R7: With `useDecoder`=1, changes on `vRefIn` and `hRefIn` have no effect. A cycle with `decFieldStart`=1 loads `decFid` (XOR `invertFid`) into `fidOut`, visible after the next rising clock edge. With `useDecoder`=0, `decFieldStart` has no effect.
- R8: An external reference change presented before rising clock edge k shows on the outputs right after rising edge k+2. The path is two synchroniser flip-flops plus the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hRefIn | input | 1 | Asynchronous horizontal reference |
| vRefIn | input | 1 | Asynchronous vertical reference |
| edgeSelRise | input | 1 | 0: falling vertical edge is the event, 1: rising |
| invertFid | input | 1 | 1: invert the detected field identifier |
| useDecoder | input | 1 | 1: take the identifier from the decoder path |
| decFid | input | 1 | Field identifier from the internal decoder |
| decFieldStart | input | 1 | One-cycle field start strobe from the decoder |
| fidOut | output | 1 | Registered field identifier |
| firstFieldPulse | output | 1 | One-cycle pulse at a first-field start |
| secondFieldPulse | output | 1 | One-cycle pulse at a second-field start |

## Verification
A wrong synchroniser or edge-history state gives a missing, doubled or mistimed field-start pulse. This shows within three clock cycles of the vertical change that caused it. A wrong held identifier stays visible on `fidOut` until the next detection event, which can be a whole field away, so the bench compares every cycle. The bench also puts horizontal changes between vertical edges to expose any leak into the held value.

// File: rtl/fid_pkg.sv
package fid_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;   // load a new field identifier this cycle
    logic rawLevel;  // identifier before polarity handling
  } fidStrobe_t;

endpackage

// File: rtl/fid_sync.sv
module fid_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/fid_ctrl.sv
module fid_ctrl
  import fid_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hRefIn,
  input  logic       vRefIn,
  input  logic       edgeSelRise,
  input  logic       useDecoder,
  input  logic       decFid,
  input  logic       decFieldStart,
  output fidStrobe_t strobe
);
  logic hSync;
  logic vSync;
  logic vPrev;
  logic vRise;
  logic vFall;
  logic extEvent;

  fid_sync #(.STAGES(SYNC_STAGES)) hSync_i (
    .clk(clk), .rstN(rstN), .din(hRefIn), .dout(hSync)
  );

  fid_sync #(.STAGES(SYNC_STAGES)) vSync_i (
    .clk(clk), .rstN(rstN), .din(vRefIn), .dout(vSync)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vPrev <= 1'b0;
    else       vPrev <= vSync;
  end

  assign vRise    = vSync & ~vPrev;
  assign vFall    = ~vSync & vPrev;
  assign extEvent = edgeSelRise ? vRise : vFall;

  always_comb begin
    if (useDecoder) begin
      strobe.capture  = decFieldStart;
      strobe.rawLevel = decFid;
    end else begin
      strobe.capture  = extEvent;
      strobe.rawLevel = hSync;
    end
  end

  AST_EXT_NEEDS_VEDGE: assert property (@(posedge clk) disable iff (!rstN)
    (!useDecoder && strobe.capture) |-> (vSync != $past(vSync))); // R2
  AST_DEC_BYPASS: assert property (@(posedge clk) disable iff (!rstN)
    (useDecoder && !decFieldStart) |-> !strobe.capture); // R7
endmodule

// File: rtl/fid_datapath.sv
module fid_datapath
  import fid_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  fidStrobe_t strobe,
  input  logic       invertFid,
  output logic       fidOut,
  output logic       firstFieldPulse,
  output logic       secondFieldPulse
);
  logic nextFid;

  assign nextFid = strobe.rawLevel ^ invertFid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fidOut           <= 1'b0;
      firstFieldPulse  <= 1'b0;
      secondFieldPulse <= 1'b0;
    end else begin
      firstFieldPulse  <= strobe.capture & ~nextFid;
      secondFieldPulse <= strobe.capture & nextFid;
      if (strobe.capture) fidOut <= nextFid;
    end
  end

  AST_FID_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> $stable(fidOut)); // R6
  AST_PULSE_NEEDS_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    (firstFieldPulse || secondFieldPulse) |-> $past(strobe.capture)); // R5
endmodule

// File: rtl/fid_detect.sv
module fid_detect
  import fid_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic hRefIn,
  input  logic vRefIn,
  input  logic edgeSelRise,
  input  logic invertFid,
  input  logic useDecoder,
  input  logic decFid,
  input  logic decFieldStart,
  output logic fidOut,
  output logic firstFieldPulse,
  output logic secondFieldPulse
);
  fidStrobe_t strobe;

  fid_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .hRefIn(hRefIn), .vRefIn(vRefIn),
    .edgeSelRise(edgeSelRise), .useDecoder(useDecoder),
    .decFid(decFid), .decFieldStart(decFieldStart), .strobe(strobe)
  );

  fid_datapath dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .invertFid(invertFid),
    .fidOut(fidOut), .firstFieldPulse(firstFieldPulse),
    .secondFieldPulse(secondFieldPulse)
  );

  AST_PULSE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({firstFieldPulse, secondFieldPulse})); // R5
  AST_FIRST_MEANS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    firstFieldPulse |-> !fidOut); // R5
  AST_SECOND_MEANS_ONE: assert property (@(posedge clk) disable iff (!rstN)
    secondFieldPulse |-> fidOut); // R5
  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rstN |-> (!fidOut && !firstFieldPulse && !secondFieldPulse)); // R1
endmodule

// File: tb/fid_detect_tb.sv
module fid_detect_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hRefIn = 0, vRefIn = 0, edgeSelRise = 0, invertFid = 0;
  logic useDecoder = 0, decFid = 0, decFieldStart = 0;
  logic fidOut, firstFieldPulse, secondFieldPulse;

  int checks = 0;
  int errors = 0;
  string curReq = "R1";
  bit done = 0;

  always #2 clk = ~clk;

  fid_detect dut_i (
    .clk(clk), .rstN(rstN), .hRefIn(hRefIn), .vRefIn(vRefIn),
    .edgeSelRise(edgeSelRise), .invertFid(invertFid), .useDecoder(useDecoder),
    .decFid(decFid), .decFieldStart(decFieldStart), .fidOut(fidOut),
    .firstFieldPulse(firstFieldPulse), .secondFieldPulse(secondFieldPulse)
  );

  // Reference model built from R2..R8: inputs seen at edge k act at edge k+2
  logic mH1 = 0, mH2 = 0, mV1 = 0, mV2 = 0, mV3 = 0;
  logic expFid = 0, expFirst = 0, expSecond = 0;

  function automatic logic isEvent(logic cur, logic prev, logic rise);
    return rise ? (cur && !prev) : (!cur && prev);
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mH1 <= 0; mH2 <= 0; mV1 <= 0; mV2 <= 0; mV3 <= 0;
      expFid <= 0; expFirst <= 0; expSecond <= 0;
    end else begin
      logic cap, lvl;
      mH1 <= hRefIn; mH2 <= mH1;
      mV1 <= vRefIn; mV2 <= mV1; mV3 <= mV2;
      cap = useDecoder ? decFieldStart : isEvent(mV2, mV3, edgeSelRise);
      lvl = (useDecoder ? decFid : mH2) ^ invertFid;
      expFirst  <= cap && !lvl;
      expSecond <= cap && lvl;
      if (cap) expFid <= lvl;
    end
  end

  task automatic check(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cmpModel();
    check(curReq, "fidOut", fidOut, expFid);
    check(curReq, "firstFieldPulse", firstFieldPulse, expFirst);
    check(curReq, "secondFieldPulse", secondFieldPulse, expSecond);
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      cmpModel();
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "fidOut", fidOut, 1'b0);
    check("R1", "firstFieldPulse", firstFieldPulse, 1'b0);
    check("R1", "secondFieldPulse", secondFieldPulse, 1'b0);
    rstN = 1;
    step(3);

    // R2 + R8: falling edge with H high gives 1, latency three edges
    curReq = "R2";
    vRefIn = 1; step(4);
    hRefIn = 1; vRefIn = 0;
    @(posedge clk); @(negedge clk);
    check("R8", "fid after 1 edge", fidOut, 1'b0);
    @(posedge clk); @(negedge clk);
    check("R8", "fid after 2 edges", fidOut, 1'b0);
    @(posedge clk); @(negedge clk);
    check("R8", "fid after 3 edges", fidOut, 1'b1);
    check("R5", "second pulse", secondFieldPulse, 1'b1);
    check("R5", "first pulse", firstFieldPulse, 1'b0);
    step(1);
    check("R5", "second pulse one cycle", secondFieldPulse, 1'b0);
    // R2: rising edge with H low is ignored
    hRefIn = 0; vRefIn = 1; step(5);
    check("R2", "rising ignored", fidOut, 1'b1);
    // R6: H toggles alone
    curReq = "R6";
    hRefIn = 1; step(3); hRefIn = 0; step(3);
    check("R6", "hold without V edge", fidOut, 1'b1);
    // R2: falling with H low -> 0 with first pulse
    curReq = "R2";
    vRefIn = 0; step(3);
    check("R2", "falling H low", fidOut, 1'b0);
    check("R5", "first pulse", firstFieldPulse, 1'b1);
    step(3);

    // R3: rising edge mode
    curReq = "R3";
    edgeSelRise = 1; hRefIn = 1; vRefIn = 1; step(3);
    check("R3", "rising sample", fidOut, 1'b1);
    hRefIn = 0; vRefIn = 0; step(5);
    check("R3", "falling ignored", fidOut, 1'b1);

    // R4: inversion on external path
    curReq = "R4";
    invertFid = 1; hRefIn = 0; vRefIn = 1; step(3);
    check("R4", "inverted external", fidOut, 1'b1);
    check("R5", "second pulse inverted", secondFieldPulse, 1'b1);
    vRefIn = 0; step(3);

    // R7: decoder path, external ignored, inversion applies
    curReq = "R7";
    useDecoder = 1; invertFid = 0;
    hRefIn = 0; vRefIn = 1; step(5);
    check("R7", "external ignored", fidOut, 1'b1);
    decFid = 0; decFieldStart = 1; step(1);
    decFieldStart = 0;
    check("R7", "decoder fid", fidOut, 1'b0);
    check("R7", "decoder first pulse", firstFieldPulse, 1'b1);
    step(1);
    invertFid = 1; decFid = 0; decFieldStart = 1; step(1);
    decFieldStart = 0;
    check("R4", "inverted decoder", fidOut, 1'b1);
    step(2);
    useDecoder = 0; decFid = 0; decFieldStart = 1; step(3);
    decFieldStart = 0;
    check("R7", "strobe ignored when external", fidOut, 1'b1);
    invertFid = 0; edgeSelRise = 0; vRefIn = 0; hRefIn = 0; step(4);

    // Constrained random mix against the model
    curReq = "R6";
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 7) == 0) vRefIn = ~vRefIn;
      if ($urandom_range(0, 3) == 0) hRefIn = ~hRefIn;
      if ($urandom_range(0, 199) == 0) edgeSelRise = ~edgeSelRise;
      if ($urandom_range(0, 149) == 0) invertFid = ~invertFid;
      if ($urandom_range(0, 249) == 0) useDecoder = ~useDecoder;
      decFid = 1'($urandom_range(0, 1));
      decFieldStart = ($urandom_range(0, 9) == 0);
      step(1);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule